// File: doc/BRIEF.md
# Main Clock Selector and Divider

This block picks one of four free-running clock sources to become the main clock, and divides that clock down to make the system clock. The sources are the internal RC oscillator, the clock that feeds the PLL, the watchdog oscillator and the PLL output. A small register interface, clocked by its own register clock, holds three registers: the source select, the update strobe and the divide value.

Writing the select register does not move the clock on its own. The choice is committed only when the update register goes from 0 to 1 by a write. Each source then hands over through a per-source enable. That enable is synchronised on the source's own falling edge. The old source is released first, and only after that is the new source admitted, so the output never carries a shortened phase. Both clocks must be toggling for the handover to finish.

The divide value can stop the system clock (0), pass the main clock straight through (1), or divide it by 2 to 255. A new divide value is picked up at the divide counter's next terminal count.

Top module: `mcs_top`

## Requirements
- R1: The committed 2-bit select code chooses the source: 0 = internal RC, 1 = PLL input clock, 2 = watchdog oscillator, 3 = PLL output (bit n of `src_clk` carries code n).
- R2: After reset the internal RC source (code 0) drives the main clock, and the select register reads 0.
- R3: The written select is applied only when a write of 1 to the update register (address 1, bit 0) finds that register holding 0. A select write alone, or a write of 1 while the update register already holds 1, leaves the active source unchanged.
- R4: Reading the select register (address 0, bits 1:0) returns the last written value, not the active source. Unused read bits are 0.
- R5: At most one source is enabled at any time. No high or low phase of `sys_clk_o` is shorter than the shortest half period of the sources involved.
- R6: A divide value of 0 holds `sys_clk_o` low.
- R7: A divide value of 1 passes the main clock through. A value N from 2 to 255 gives a period of N main-clock cycles, high for ceil(N/2) of them. A changed value takes effect at the next terminal count.
- R8: The divide register (address 2, bits 7:0) resets to 1 and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register interface clock |
| rst | input | 1 | Synchronous active-high reset; must be held for several cycles of every source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 select, 1 update, 2 divide |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| src_clk | input | 4 | Source clocks, bit index equals select code |
| sys_clk_o | output | 1 | Divided system clock |

## Verification
Some checks run on every cycle. They confirm that the active source moves only on an update write that finds the update register at 0. They confirm that the select register holds the last written value and that both registers take their reset values. They confirm that the one-hot-or-zero property holds across the per-source enables, and that the divide counter stays inside the active ratio. Other behaviour can only be shown by the bench, which measures `sys_clk_o` in time: the period produced by each select code, the divided period and duty for even and odd ratios, the stopped clock, and the shortest high and low phases seen over every switch and ratio change.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int NUM_SRC     = 4;
    localparam int SEL_W       = $clog2(NUM_SRC);
    localparam int ADDR_W      = 2;
    localparam int DATA_W      = 8;
    localparam int DIV_W       = 8;
    localparam int SYNC_STAGES = 2;

    // select codes: bit position in src_clk equals code
    typedef enum logic [SEL_W-1:0] {
        SRC_IRC     = 2'd0,
        SRC_PLL_IN  = 2'd1,
        SRC_WDOG    = 2'd2,
        SRC_PLL_OUT = 2'd3
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        ADR_SEL  = 2'd0,
        ADR_UPD  = 2'd1,
        ADR_DIV  = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        reg_addr_e         addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    // architectural register state
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             upd;
        src_e             active;
        logic [DIV_W-1:0] div;
    } reg_state_t;

    function automatic logic [SEL_W-1:0] sel_field(input logic [DATA_W-1:0] d);
        return d[SEL_W-1:0];
    endfunction

endpackage

// File: rtl/mcs_regs.sv
module mcs_regs
    import mcs_pkg::*;
#(
    parameter int DIV_W_P = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    output logic [DATA_W-1:0] rdata,
    output logic [SEL_W-1:0]  active_sel,
    output logic [DIV_W_P-1:0] div_val
);

    localparam logic [DIV_W_P-1:0] DIV_RESET = DIV_W_P'(1);

    reg_state_t st_q;
    logic       upd_rise;

    // commit only when a 1 lands on an update register that holds 0
    assign upd_rise = req.wr && (req.addr == ADR_UPD) && req.wdata[0] && !st_q.upd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sel    <= '0;
            st_q.upd    <= 1'b0;
            st_q.active <= SRC_IRC;
            st_q.div    <= DIV_RESET;
        end else begin
            if (req.wr) begin
                case (req.addr)
                    ADR_SEL: st_q.sel <= sel_field(req.wdata);
                    ADR_UPD: st_q.upd <= req.wdata[0];
                    ADR_DIV: st_q.div <= req.wdata[DIV_W_P-1:0];
                    default: ;
                endcase
            end
            if (upd_rise) begin
                st_q.active <= src_e'(st_q.sel);
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (req.addr)
            ADR_SEL: rdata[SEL_W-1:0]   = st_q.sel;
            ADR_UPD: rdata[0]           = st_q.upd;
            ADR_DIV: rdata[DIV_W_P-1:0] = st_q.div;
            default: rdata = '0;
        endcase
    end

    assign active_sel = st_q.active;
    assign div_val    = st_q.div;

endmodule

// File: rtl/mcs_src_gate.sv
module mcs_src_gate #(
    parameter int   STAGES   = 2,
    parameter logic RESET_ON = 1'b0
) (
    input  logic src_clk,
    input  logic rst,
    input  logic want,
    input  logic others_on,
    output logic en
);

    logic [STAGES-1:0] chain_q;

    // every stage on the source's own falling edge: the enable changes
    // only while the source is low, so the gated clock keeps full phases
    always_ff @(negedge src_clk) begin
        if (rst) begin
            chain_q <= {STAGES{RESET_ON}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], want & ~others_on};
        end
    end

    assign en = chain_q[STAGES-1];

endmodule

// File: rtl/mcs_divider.sv
module mcs_divider #(
    parameter int DIV_W_P  = 8,
    parameter int STAGES   = 2
) (
    input  logic               mclk,
    input  logic               rst,
    input  logic [DIV_W_P-1:0] div_val,
    output logic               clk_o
);

    localparam logic [DIV_W_P-1:0] ONE = DIV_W_P'(1);
    localparam logic [DIV_W_P-1:0] TWO = DIV_W_P'(2);

    logic [STAGES-1:0][DIV_W_P-1:0] dsync_q;
    logic [DIV_W_P-1:0] ratio_q;
    logic [DIV_W_P-1:0] cnt_q;
    logic [DIV_W_P-1:0] cnt_nx;
    logic [DIV_W_P-1:0] high_len;
    logic [DIV_W_P-1:0] new_ratio;
    logic               term;
    logic               dq;
    logic               pass_q;

    // ratio value is quasi-static; carried over by a plain flop chain
    always_ff @(posedge mclk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) dsync_q[i] <= ONE;
        end else begin
            dsync_q[0] <= div_val;
            for (int i = 1; i < STAGES; i++) dsync_q[i] <= dsync_q[i-1];
        end
    end

    assign new_ratio = dsync_q[STAGES-1];
    assign high_len  = (ratio_q >> 1) + {{(DIV_W_P-1){1'b0}}, ratio_q[0]};
    assign term      = (ratio_q <= ONE) || (cnt_q == ratio_q - ONE);
    assign cnt_nx    = cnt_q + ONE;

    always_ff @(posedge mclk) begin
        if (rst) begin
            ratio_q <= ONE;
            cnt_q   <= '0;
            dq      <= 1'b0;
        end else if (term) begin
            ratio_q <= new_ratio;
            cnt_q   <= '0;
            dq      <= (new_ratio >= TWO);
        end else begin
            cnt_q   <= cnt_nx;
            dq      <= (cnt_nx < high_len);
        end
    end

    // pass-through enable moves only while the main clock is low
    always_ff @(negedge mclk) begin
        if (rst) pass_q <= 1'b0;
        else     pass_q <= (ratio_q == ONE);
    end

    assign clk_o = (mclk & pass_q) | dq;

endmodule

// File: rtl/mcs_top.sv
module mcs_top
    import mcs_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int DIV_BITS = DIV_W,
    parameter int N_SYNC  = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  src_clk,
    output logic              sys_clk_o
);

    localparam int SW = $clog2(N_SRC);

    reg_req_t             req;
    logic [SEL_W-1:0]     active_sel;
    logic [DIV_BITS-1:0]  div_val;
    logic [N_SRC-1:0]     src_en;
    logic                 mclk;

    assign req.wr    = reg_wr;
    assign req.addr  = reg_addr_e'(reg_addr);
    assign req.wdata = reg_wdata;

    mcs_regs #(.DIV_W_P(DIV_BITS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .rdata      (reg_rdata),
        .active_sel (active_sel),
        .div_val    (div_val)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic want;
        logic others_on;
        assign want      = (active_sel == SW'(g));
        assign others_on = |(src_en & ~(N_SRC'(1) << g));
        mcs_src_gate #(
            .STAGES   (N_SYNC),
            .RESET_ON (g == 0)
        ) u_gate (
            .src_clk   (src_clk[g]),
            .rst       (rst),
            .want      (want),
            .others_on (others_on),
            .en        (src_en[g])
        );
    end

    assign mclk = |(src_clk & src_en);

    mcs_divider #(.DIV_W_P(DIV_BITS), .STAGES(N_SYNC)) u_div (
        .mclk    (mclk),
        .rst     (rst),
        .div_val (div_val),
        .clk_o   (sys_clk_o)
    );

endmodule

// File: rtl/mcs_checkers.sv
module mcs_regs_chk
    import mcs_pkg::*;
#(
    parameter int DIV_W_P = DIV_W
) (
    input logic         clk,
    input logic         rst,
    input reg_req_t     req,
    input reg_state_t   st_q
);

    // R3: active source changes only after an update write that found 0
    a_r3_commit_on_rise: assert property (@(posedge clk) disable iff (rst)
        (st_q.active != $past(st_q.active)) |->
        $past(req.wr && req.addr == ADR_UPD && req.wdata[0] && !st_q.upd));

    // R3: update write while already 1 does not move the source
    a_r3_held_no_commit: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == ADR_UPD && st_q.upd) |=> $stable(st_q.active));

    // R4: select register keeps what was written
    a_r4_sel_readback: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == ADR_SEL) |=> (st_q.sel == $past(req.wdata[SEL_W-1:0])));

    // R2: RC source selected out of reset
    a_r2_reset_source: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_q.active == SRC_IRC && st_q.sel == '0));

    // R8: divide value resets to 1
    a_r8_div_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_q.div == DIV_W'(1)));

endmodule

module mcs_top_chk #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_en
);

    // R5: never two sources gated onto the main clock
    a_r5_one_source: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_en));

    // R2: RC source enable is the only one on after reset
    a_r2_irc_enabled: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (src_en == N_SRC'(1)));

endmodule

module mcs_div_chk #(
    parameter int DIV_W_P = 8
) (
    input logic               mclk,
    input logic               rst,
    input logic [DIV_W_P-1:0] ratio_q,
    input logic [DIV_W_P-1:0] cnt_q
);

    // R7: counter stays inside the active ratio
    a_r7_cnt_bound: assert property (@(posedge mclk) disable iff (rst)
        (ratio_q >= DIV_W_P'(2)) |-> (cnt_q < ratio_q));

    // R6/R7: stopped or pass-through ratio keeps the counter idle
    a_r6_idle_count: assert property (@(posedge mclk) disable iff (rst)
        (ratio_q <= DIV_W_P'(1)) |-> (cnt_q == '0));

endmodule

bind mcs_regs mcs_regs_chk #(.DIV_W_P(DIV_W_P)) u_regs_chk (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .st_q (st_q)
);

bind mcs_top mcs_top_chk #(.N_SRC(N_SRC)) u_top_chk (
    .clk    (clk),
    .rst    (rst),
    .src_en (src_en)
);

bind mcs_divider mcs_div_chk #(.DIV_W_P(DIV_W_P)) u_div_chk (
    .mclk    (mclk),
    .rst     (rst),
    .ratio_q (ratio_q),
    .cnt_q   (cnt_q)
);

// File: tb/mcs_top_bench.sv
`timescale 1ns/1ps
module mcs_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       c_irc = 1'b0, c_pin = 1'b0, c_wdg = 1'b0, c_pout = 1'b0;
    logic [3:0] src_clk;
    logic       sys_clk_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4    clk    = ~clk;     // 125 MHz
    always #5    c_irc  = ~c_irc;   // 10 ns
    always #7    c_pin  = ~c_pin;   // 14 ns
    always #11   c_wdg  = ~c_wdg;   // 22 ns
    always #3    c_pout = ~c_pout;  // 6 ns

    assign src_clk = {c_pout, c_wdg, c_pin, c_irc};

    mcs_top u_mcs_top (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_clk   (src_clk),
        .sys_clk_o (sys_clk_o)
    );

    // output clock monitor
    bit  mon_on = 1'b0;
    bit  have_rise = 1'b0, have_fall = 1'b0;
    int  edge_cnt = 0;
    real last_rise = 0.0, prev_rise = 0.0, last_fall = 0.0;
    real last_high = 0.0;
    real min_high = 1.0e9, min_low = 1.0e9;

    always @(posedge sys_clk_o) begin
        prev_rise = last_rise;
        last_rise = $realtime;
        edge_cnt++;
        if (mon_on && have_fall && (last_rise - last_fall) < min_low)
            min_low = last_rise - last_fall;
        have_rise = 1'b1;
    end

    always @(negedge sys_clk_o) begin
        last_fall = $realtime;
        if (have_rise) begin
            last_high = last_fall - last_rise;
            if (mon_on && last_high < min_high) min_high = last_high;
        end
        have_fall = 1'b1;
    end

    task automatic check_val(input bit ok, input string req, input string what,
                             input real act, input real exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what,
                              input real act, input real exp);
        real d;
        d = act - exp;
        if (d < 0.0) d = -d;
        check_val(d < 0.5, req, what, act, exp);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // period between the last two of three fresh rising edges (0 if none)
    task automatic measure(output real p);
        int  start;
        real t0;
        start = edge_cnt;
        t0    = $realtime;
        while (edge_cnt < start + 3 && ($realtime - t0) < 20000.0) #1;
        if (edge_cnt >= start + 3) p = last_rise - prev_rise;
        else                      p = 0.0;
    endtask

    task automatic commit_source(input logic [1:0] code);
        reg_write(2'd0, {6'd0, code});
        reg_write(2'd1, 8'd0);
        reg_write(2'd1, 8'd1);
        #400;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        real p;
        reg_read(2'd0, d);
        check_val(d == 8'd0, "R2", "select after reset", real'(d), 0.0);
        reg_read(2'd1, d);
        check_val(d == 8'd0, "R3", "update after reset", real'(d), 0.0);
        reg_read(2'd2, d);
        check_val(d == 8'd1, "R8", "divide after reset", real'(d), 1.0);
        measure(p);
        check_near("R2", "period from RC source", p, 10.0);
    endtask

    task automatic t_select_needs_update;
        logic [7:0] d;
        real p;
        reg_write(2'd0, 8'd3);
        #400;
        measure(p);
        check_near("R3", "select write alone keeps RC", p, 10.0);
        reg_read(2'd0, d);
        check_val(d == 8'd3, "R4", "select readback before commit", real'(d), 3.0);
    endtask

    task automatic t_update_rise;
        real p;
        reg_write(2'd1, 8'd1);
        #400;
        measure(p);
        check_near("R1", "code 3 gives PLL output period", p, 6.0);
    endtask

    task automatic t_update_held;
        logic [7:0] d;
        real p;
        reg_write(2'd0, 8'd2);
        reg_write(2'd1, 8'd1);
        #400;
        measure(p);
        check_near("R3", "write of 1 over 1 keeps source", p, 6.0);
        reg_read(2'd0, d);
        check_val(d == 8'd2, "R4", "readback shows written not active", real'(d), 2.0);
        reg_write(2'd1, 8'd0);
        reg_write(2'd1, 8'd1);
        #400;
        measure(p);
        check_near("R1", "code 2 gives watchdog period", p, 22.0);
    endtask

    task automatic t_divide;
        logic [7:0] d;
        real p;
        int  e0;
        reg_write(2'd2, 8'd2);
        #500;
        measure(p);
        check_near("R7", "divide by 2 period", p, 44.0);
        reg_read(2'd2, d);
        check_val(d == 8'd2, "R8", "divide readback", real'(d), 2.0);
        reg_write(2'd2, 8'd3);
        #500;
        measure(p);
        check_near("R7", "divide by 3 period", p, 66.0);
        check_near("R7", "divide by 3 high phase", last_high, 44.0);
        reg_write(2'd2, 8'd0);
        #500;
        e0 = edge_cnt;
        #1000;
        check_val(edge_cnt == e0, "R6", "edges with divide 0", real'(edge_cnt - e0), 0.0);
        check_val(sys_clk_o == 1'b0, "R6", "level with divide 0", real'(sys_clk_o), 0.0);
        reg_write(2'd2, 8'd1);
        #500;
        measure(p);
        check_near("R7", "divide 1 passes through", p, 22.0);
    endtask

    task automatic t_other_sources;
        real p;
        commit_source(2'd1);
        measure(p);
        check_near("R1", "code 1 gives PLL input period", p, 14.0);
        commit_source(2'd0);
        measure(p);
        check_near("R1", "code 0 gives RC period", p, 10.0);
    endtask

    task automatic t_divide_max;
        real p;
        reg_write(2'd2, 8'd255);
        #500;
        measure(p);
        check_near("R7", "divide by 255 period", p, 2550.0);
        check_near("R7", "divide by 255 high phase", last_high, 1280.0);
        reg_write(2'd2, 8'd1);
        #3000;
        measure(p);
        check_near("R7", "back to pass-through", p, 10.0);
    endtask

    task automatic t_glitch;
        check_val(min_high >= 2.9, "R5", "shortest high phase", min_high, 3.0);
        check_val(min_low  >= 2.9, "R5", "shortest low phase",  min_low,  3.0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (30) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #200;
        mon_on = 1'b1;
        t_reset();
        t_select_needs_update();
        t_update_rise();
        t_update_held();
        t_divide();
        t_other_sources();
        t_divide_max();
        t_glitch();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule